// File: doc/BRIEF.md
# E1 Frame Parity Monitor

This block watches the serial data of an E1 transmit backplane, one bit per bit-clock cycle, and checks a parity bit that the sender places in each frame. A frame is `FRAME_BITS` bits long (256 on a real E1 link: 32 timeslots of 8 bits). Bit 0 of a frame is the first bit of timeslot 0. That bit carries the parity of the frame before it. The monitor counts the ones across each frame and compares the result with the carrier bit that arrives at the start of the next frame. A mismatch sets a sticky error flag, and the flag can also drive an interrupt.

Frame alignment comes from a frame pulse input. The active level of the pulse is programmable. In single-frame mode, the active level lasts for bit 0 of a frame. In multiframe mode, the line goes active at the start of a 16-frame signalling multiframe and flips back at the start of the second 8-frame CRC multiframe. Each level change then marks bit 0 of a frame. Between sync events, a free-running bit counter keeps the frame boundaries. A sync event that lands off the counted boundary realigns the counter. The frame after any realignment, or after first lock, is never checked.

Software reaches one 8-bit register through a write strobe and a read strobe. A read clears the error flag.

Top module: `e1_parity_monitor`

## Requirements
- R1: In single-frame mode (mode bit 1 = 0), a sample of the frame pulse at its active level marks that bit as bit 0 of a frame. With the polarity bit (bit 0) at 0, the active level is high.
- R2: With the polarity bit at 1, the active level of the frame pulse is low.
- R3: In multiframe mode (mode bit 1 = 1), every change in the level of the frame pulse marks that bit as bit 0 of a frame.
- R4: With the parity-sense bit (bit 7) at 0, the carrier bit must be 1 exactly when the previous frame held an odd number of ones. Any other value is an error.
- R5: With the parity-sense bit at 1, the carrier bit must be 1 exactly when the previous frame held an even number of ones.
- R6: The include bit (bit 3) controls whether bit 0 of the previous frame counts toward its ones total (1 = counted, 0 = left out). The value used is the one in force at that frame's start.
- R7: No check is made on the carrier at a sync event that is either the first one or lands off the counted boundary. Before the first sync event, no check is made at all.
- R8: Once locked, a check is made every `FRAME_BITS` bits even when no frame pulse arrives.
- R9: An error sets the status bit (bit 5) in the cycle after the carrier bit. The status bit stays set until a read strobe clears it. Writes do not change it.
- R10: An error in the same cycle as a read strobe leaves the status bit set.
- R11: The interrupt output is high exactly when both the status bit and the enable bit (bit 6) are 1.
- R12: The read port shows bits 7, 6, 3, 1 and 0 as written and shows the status bit in bit 5. Bits 4 and 2 read as 0. All bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one data bit per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serData | input | 1 | Serial backplane data |
| framePulse | input | 1 | Frame or multiframe sync pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; clears the status bit |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the monitor with `FRAME_BITS` = 32, which keeps each frame short. That puts dozens of frames, including a full 16-frame multiframe cycle plus a second pass to its midpoint, within a few thousand cycles. The short frames also make room for truncated frames that force a realignment in both pulse modes. With them, every configuration change can be followed by several checked frames, both good and corrupted.

// File: rtl/e1par_pkg.sv
package e1par_pkg;

  // Register bit positions (software decodes these)
  localparam int BIT_PAR_ODD = 7;
  localparam int BIT_IRQ_EN  = 6;
  localparam int BIT_ERR     = 5;
  localparam int BIT_EXTEND  = 3;
  localparam int BIT_MODE    = 1;
  localparam int BIT_POL     = 0;

  typedef struct packed {
    logic parOdd;     // 1: odd sense
    logic irqEn;      // interrupt enable
    logic extend;     // count carrier bit of the frame
    logic pulseMode;  // 1: multiframe edges
    logic pulsePol;   // 1: active-low pulse
  } cfgRegs_t;

  typedef struct packed {
    logic frameStart; // current bit is bit 0 of a frame
    logic checkNow;   // current bit is a carrier to be checked
  } frameStrobes_t;

endpackage

// File: rtl/e1par_ctrl.sv
module e1par_ctrl
  import e1par_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          framePulse,
  input  cfgRegs_t      cfg,
  output frameStrobes_t strobes
);

  localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] AFTER_START = (FRAME_BITS > 1) ? CNT_W'(1) : '0;

  logic [CNT_W-1:0] bitCntQ, bitCntD;
  logic lockedQ;
  logic prevLvlQ;
  logic pulseLvl;
  logic syncNow;
  logic atZero;

  always_comb begin
    pulseLvl = framePulse ^ cfg.pulsePol;
    syncNow  = cfg.pulseMode ? (pulseLvl ^ prevLvlQ) : pulseLvl;
    atZero   = lockedQ && (bitCntQ == '0);
    // A sync on the counted boundary is consistent; off it, a realignment.
    strobes.frameStart = syncNow || atZero;
    strobes.checkNow   = atZero;
  end

  always_comb begin
    if (strobes.frameStart)      bitCntD = AFTER_START;
    else if (bitCntQ == LAST_BIT) bitCntD = '0;
    else                         bitCntD = bitCntQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCntQ  <= '0;
      lockedQ  <= 1'b0;
      prevLvlQ <= 1'b0;
    end else begin
      bitCntQ  <= bitCntD;
      lockedQ  <= lockedQ | syncNow;
      prevLvlQ <= pulseLvl;
    end
  end

endmodule

// File: rtl/e1par_datapath.sv
module e1par_datapath
  import e1par_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          serData,
  input  cfgRegs_t      cfg,
  input  frameStrobes_t strobes,
  output logic          parErr
);

  logic accQ;       // running parity of the frame in progress
  logic expCarrier;

  always_comb begin
    expCarrier = accQ ^ cfg.parOdd;
    parErr     = strobes.checkNow && (serData != expCarrier);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   accQ <= 1'b0;
    else if (strobes.frameStart) accQ <= serData & cfg.extend;
    else                         accQ <= accQ ^ serData;
  end

endmodule

// File: rtl/e1par_regs.sv
module e1par_regs
  import e1par_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  input  logic       parErr,
  output cfgRegs_t   cfg,
  output logic [7:0] regRdData,
  output logic       irq
);

  logic errQ;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[5], regWrData[4], regWrData[2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (regWrEn) begin
      cfg.parOdd    <= regWrData[BIT_PAR_ODD];
      cfg.irqEn     <= regWrData[BIT_IRQ_EN];
      cfg.extend    <= regWrData[BIT_EXTEND];
      cfg.pulseMode <= regWrData[BIT_MODE];
      cfg.pulsePol  <= regWrData[BIT_POL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        errQ <= 1'b0;
    else if (parErr)  errQ <= 1'b1;
    else if (regRdEn) errQ <= 1'b0;
  end

  always_comb begin
    regRdData              = '0;
    regRdData[BIT_PAR_ODD] = cfg.parOdd;
    regRdData[BIT_IRQ_EN]  = cfg.irqEn;
    regRdData[BIT_ERR]     = errQ;
    regRdData[BIT_EXTEND]  = cfg.extend;
    regRdData[BIT_MODE]    = cfg.pulseMode;
    regRdData[BIT_POL]     = cfg.pulsePol;
    irq                    = errQ & cfg.irqEn;
  end

endmodule

// File: rtl/e1_parity_monitor.sv
module e1_parity_monitor
  import e1par_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serData,
  input  logic       framePulse,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq
);

  cfgRegs_t      cfg;
  frameStrobes_t strobes;
  logic          parErr;

  e1par_ctrl #(.FRAME_BITS(FRAME_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .cfg(cfg), .strobes(strobes)
  );

  e1par_datapath i_dp (
    .clk(clk), .rstN(rstN), .serData(serData), .cfg(cfg), .strobes(strobes), .parErr(parErr)
  );

  e1par_regs i_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .parErr(parErr), .cfg(cfg), .regRdData(regRdData), .irq(irq)
  );

endmodule

// File: rtl/e1par_checker.sv
module e1par_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regRdEn,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic       irq,
  input logic       parErr
);

  p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> regRdData[6]);

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[5] && regRdData[6]) |-> irq);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[5] && !regRdEn) |=> regRdData[5]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !parErr) |=> !regRdData[5]);

  p_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    parErr |=> regRdData[5]);

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[5]) |-> $past(parErr));

  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable({regRdData[7:6], regRdData[3], regRdData[1:0]}));

endmodule

bind e1_parity_monitor e1par_checker i_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn),
  .regRdData(regRdData), .irq(irq), .parErr(parErr)
);

// File: tb/test_e1_parity_monitor.sv
module test_e1_parity_monitor;
  localparam int NB = 32;

  logic clk = 1'b0, rstN = 1'b0, serData = 1'b0, framePulse = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq;

  always #10 clk = ~clk;

  e1_parity_monitor #(.FRAME_BITS(NB)) i_e1_parity_monitor (
    .clk(clk), .rstN(rstN), .serData(serData), .framePulse(framePulse),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  typedef struct { logic [7:0] rd; logic irq; string tag; } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0;
  logic [7:0] cfgM = '0;
  logic statM = 1'b0, prevPar = 1'b0, curLvl = 1'b0;
  int mfIdx = 0;
  logic [15:0] lfsr = 16'hACE1;
  string curTag = "R12 reset";
  bit done = 1'b0;

  function automatic logic nextRnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic logic fpFor(int i, logic pulse);
    if (cfgM[1]) return curLvl ^ cfgM[0];
    return ((i == 0) && pulse) ^ cfgM[0];
  endfunction

  // Driver: one bit per cycle, expected register view pushed after the edge
  task automatic sendBit(input logic d, input logic fp, input logic rd, input logic wr,
                         input logic [7:0] wd, input logic err);
    @(negedge clk);
    serData = d; framePulse = fp; regRdEn = rd; regWrEn = wr; regWrData = wd;
    @(posedge clk);
    if (err) statM = 1'b1;
    else if (rd) statM = 1'b0;
    if (wr) cfgM = wd & 8'hCB;
    expQ.push_back('{cfgM | {2'b00, statM, 5'b00000}, statM & cfgM[6], curTag});
  endtask

  task automatic sendFrame(input logic bad, input logic chk, input logic pulse,
                           input int rdAt = -1, input int wrAt = -1,
                           input logic [7:0] wd = 8'h00, input int len = NB);
    logic carrier, par;
    if (cfgM[1]) begin
      curLvl = (mfIdx < 8);
      mfIdx  = (mfIdx + 1) % 16;
    end
    carrier = prevPar ^ cfgM[7] ^ bad;
    par = cfgM[3] & carrier;
    sendBit(carrier, fpFor(0, pulse), rdAt == 0, wrAt == 0, wd, chk & bad);
    for (int i = 1; i < len; i++) begin
      logic d;
      d = nextRnd();
      par ^= d;
      sendBit(d, fpFor(i, pulse), rdAt == i, wrAt == i, wd, 1'b0);
    end
    prevPar = par;
  endtask

  // Monitor: compares the scoreboard against the ports mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (regRdData !== e.rd || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: regRdData=%h irq=%b expected regRdData=%h irq=%b",
                   e.tag, regRdData, irq, e.rd, e.irq);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: done=%0d expected 1", done);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sendBit(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);            // R12 reset view

    curTag = "R7 no check before lock";
    sendFrame(1, 0, 0); sendFrame(1, 0, 0);
    curTag = "R1 R7 first pulse not checked";
    sendFrame(1, 0, 1);
    curTag = "R1 R4 even good";
    repeat (3) sendFrame(0, 1, 1);
    curTag = "R4 even bad";
    sendFrame(1, 1, 1);
    curTag = "R9 clear on read";
    sendFrame(0, 1, 1, 3);
    curTag = "R9 R12 status not writable";
    sendFrame(0, 1, 1, -1, 2, 8'h20);
    curTag = "R11 enable irq";
    sendFrame(0, 1, 1, -1, 1, 8'h40);
    sendFrame(1, 1, 1);
    curTag = "R10 error with read";
    sendFrame(1, 1, 1, 0);
    sendFrame(0, 1, 1, 1);

    curTag = "R5 odd sense";
    sendFrame(0, 1, 1, -1, 1, 8'hC0);
    repeat (2) sendFrame(0, 1, 1);
    sendFrame(1, 1, 1);
    sendFrame(0, 1, 1, 1);

    curTag = "R6 include carrier";
    sendFrame(0, 1, 1, -1, 1, 8'hC8);
    repeat (4) sendFrame(0, 1, 1);
    sendFrame(1, 1, 1);
    sendFrame(0, 1, 1, 2);

    curTag = "R8 flywheel";
    repeat (3) sendFrame(0, 1, 0);
    sendFrame(1, 1, 0);
    sendFrame(0, 1, 0, 1);

    curTag = "R7 realign single-frame";
    sendFrame(0, 1, 1, -1, -1, 8'h00, NB - 5);
    sendFrame(1, 0, 1);
    sendFrame(0, 1, 1);
    sendFrame(1, 1, 1);
    sendFrame(0, 1, 1, 1);

    curTag = "R2 active-low pulse";
    sendFrame(0, 1, 1, -1, 1, 8'hC9);
    repeat (2) sendFrame(0, 1, 1);
    sendFrame(1, 1, 1);
    sendFrame(0, 1, 1, 1);

    curTag = "R3 multiframe edges";
    curLvl = 1'b0; mfIdx = 0;
    sendFrame(0, 1, 1, -1, 1, 8'hCB);
    for (int k = 0; k < 20; k++)
      sendFrame(k == 5 || k == 12, 1, 0, (k == 6 || k == 13) ? 1 : -1);
    while (mfIdx != 7) sendFrame(0, 1, 0);
    curTag = "R3 R7 realign multiframe";
    sendFrame(0, 1, 0, -1, -1, 8'h00, NB - 3);
    sendFrame(1, 0, 0);
    sendFrame(0, 1, 0);
    sendFrame(1, 1, 0);
    sendFrame(0, 1, 0, 1);

    curTag = "R12 idle";
    sendBit(1'b0, curLvl ^ cfgM[0], 1'b0, 1'b0, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule